// File: doc/BRIEF.md
# Peripheral Request Router with Interrupt Summary

This block sits between a set of peripheral DMA request lines and the channel engines of a DMA controller. Software programs one mapping register for each request line. The register names the channel that the line feeds and carries a valid flag. Every cycle, the block forms each channel's request as the OR of all enabled lines mapped to it and registers the result. A line whose mapping is cleared, or that names a channel the build does not have, drives nothing.

The same register port also exposes an interrupt summary. Each channel presents a level-sensitive "something pending" flag. The block captures these flags into a read-only summary word with one bit per channel. It also drives a single combined interrupt output, so that all channels can share one interrupt line and the handler can find the sources by reading the summary word. A system that wires each channel's flag to its own line can ignore the combined output.

Top module: `dreq_route_hub`

## Requirements
- R1: After synchronous reset, `ch_req` and `irq_any` are zero, and every mapping reads back as zero.
- R2: The mapping for request line n < 64 is at byte address 0x100 + 4·n. Bit 7 of the register is the valid flag and bits 4:0 are the target channel. A read returns these bits with all other bits zero, one cycle after the read strobe.
- R3: The mapping for request line n ≥ 64 is at byte address 0x1100 + 4·(n − 64), with the same field layout as R2.
- R4: A valid mapping of line n to channel c makes `ch_req[c]` follow `req_in[n]` with one register stage of latency.
- R5: A mapping with bit 7 clear drives no channel. Writing zero to a mapping register removes the route and reads back as zero.
- R6: A mapping that names a channel number at or above `NUM_CH` drives no channel.
- R7: The summary word at byte address 0xF0 holds, in bit c, channel c's pending flag as sampled one cycle earlier. Writes to this address change nothing.
- R8: `irq_any` is high exactly when at least one summary bit is set, and it is updated in the same cycle as the summary word.
- R9: Reads from addresses outside the summary and the two mapping windows return zero. Writes to such addresses alter no mapping.
- R10: When several valid lines are mapped to one channel, that channel's request is the OR of those lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| req_in | input | NUM_REQ | Peripheral request lines |
| ch_irq_flags | input | NUM_CH | Per-channel pending-interrupt flags |
| ch_req | output | NUM_CH | Registered per-channel requests |
| irq_any | output | 1 | Registered combined interrupt |

## Verification
The hardest case to reach is channel-range rejection. With the default of 32 channels, every 5-bit channel field is legal, so R6 cannot be reached at the default. The bench therefore builds the block with 24 channels and maps lines to channels 24 and 30. A table of single-line mappings covers both window edges (lines 0, 63, 64 and 127). Each table entry fires only its own line and checks that exactly the expected channel bit, or none, rises. A write to an unmapped address that aliases line 0's slot bits is followed by a readback of line 0, which shows whether the decode ignores the page bits.

// File: rtl/dreq_hub_pkg.sv
package dreq_hub_pkg;
  localparam int DATA_W      = 32;
  localparam int CH_FIELD_W  = 5;
  localparam int VALID_POS   = 7;
  localparam int WIN_LINES   = 64;
  localparam int PAGE_LO     = 'h01;
  localparam int PAGE_HI     = 'h11;
  localparam int SUMMARY_OFS = 'hF0;

  typedef struct packed {
    logic                  valid;
    logic [CH_FIELD_W-1:0] ch;
  } map_ent_t;
endpackage

// File: rtl/map_regfile.sv
module map_regfile
  import dreq_hub_pkg::*;
#(
  parameter int NUM_REQ = 128,
  parameter int ADDR_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output map_ent_t          map_q [NUM_REQ],
  output logic              hit,
  output logic [7:0]        rd_byte
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [ADDR_W-9:0] page;
  logic [5:0]        slot;
  logic              in_lo, in_hi;
  logic [7:0]        idx_full;
  logic [IDX_W-1:0]  idx_sel;

  always_comb begin
    page     = addr[ADDR_W-1:8];
    slot     = addr[7:2];
    in_lo    = (int'(page) == PAGE_LO);
    in_hi    = (int'(page) == PAGE_HI);
    idx_full = {1'b0, in_hi, slot};
    hit      = (in_lo || in_hi) && (int'(idx_full) < NUM_REQ);
    idx_sel  = hit ? idx_full[IDX_W-1:0] : '0;
  end

  for (genvar n = 0; n < NUM_REQ; n++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        map_q[n] <= '0;
      else if (wr && hit && (int'(idx_full) == n))
        map_q[n] <= '{valid: wdata[VALID_POS], ch: wdata[CH_FIELD_W-1:0]};
    end
  end

  always_comb begin
    rd_byte = '0;
    if (hit) begin
      rd_byte[VALID_POS]      = map_q[idx_sel].valid;
      rd_byte[CH_FIELD_W-1:0] = map_q[idx_sel].ch;
    end
  end

  AST_ZERO_WRITE_UNMAPS: assert property (@(posedge clk) disable iff (rst)
    (wr && hit && (wdata == 8'h00)) |=> !map_q[$past(idx_sel)].valid); // R5
endmodule

// File: rtl/req_xbar.sv
module req_xbar
  import dreq_hub_pkg::*;
#(
  parameter int NUM_REQ = 128,
  parameter int NUM_CH  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_in,
  input  map_ent_t           map_q [NUM_REQ],
  output logic [NUM_CH-1:0]  ch_req
);
  logic [NUM_CH-1:0] route_d;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      route_d[c] = 1'b0;
      for (int n = 0; n < NUM_REQ; n++)
        if (map_q[n].valid && (int'(map_q[n].ch) == c) && req_in[n])
          route_d[c] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ch_req <= '0;
    else     ch_req <= route_d;
  end

  AST_NO_REQ_FROM_SILENCE: assert property (@(posedge clk) disable iff (rst)
    ($past(req_in) == '0) |-> (ch_req == '0)); // R4
endmodule

// File: rtl/irq_collect.sv
module irq_collect #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] sum_q,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= flags;
      irq_q <= |flags;
    end
  end

  AST_SUM_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ($past(flags) == '0) |-> (sum_q == '0)); // R7
  AST_IRQ_AGREES_SUM: assert property (@(posedge clk) disable iff (rst)
    irq_q == (sum_q != '0)); // R8
endmodule

// File: rtl/dreq_route_hub.sv
module dreq_route_hub
  import dreq_hub_pkg::*;
#(
  parameter int NUM_REQ = 128,
  parameter int NUM_CH  = 32,
  parameter int ADDR_W  = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_REQ-1:0] req_in,
  input  logic [NUM_CH-1:0]  ch_irq_flags,
  output logic [NUM_CH-1:0]  ch_req,
  output logic               irq_any
);
  map_ent_t          map_q [NUM_REQ];
  logic              map_hit;
  logic [7:0]        map_byte;
  logic [NUM_CH-1:0] sum_q;
  logic              sum_sel;
  logic [31:0]       rd_mux;

  map_regfile #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_map (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[7:0]), .map_q(map_q), .hit(map_hit), .rd_byte(map_byte)
  );

  req_xbar #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_xbar (
    .clk(clk), .rst(rst), .req_in(req_in), .map_q(map_q), .ch_req(ch_req)
  );

  irq_collect #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst), .flags(ch_irq_flags), .sum_q(sum_q), .irq_q(irq_any)
  );

  always_comb begin
    sum_sel = (int'(reg_addr[ADDR_W-1:2]) == (SUMMARY_OFS >> 2));
    rd_mux  = '0;
    if (sum_sel)      rd_mux[NUM_CH-1:0] = sum_q;
    else if (map_hit) rd_mux[7:0]        = map_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !sum_sel && !map_hit) |=> (reg_rdata == '0)); // R9
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (!reg_rd && !$past(rst)) |=> $stable(reg_rdata)); // R2
endmodule

// File: tb/dreq_route_hub_test.sv
module dreq_route_hub_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ  = 128;
  localparam int NCH   = 24;
  localparam int AW    = 13;

  logic            clk = 0;
  logic            rst = 1;
  logic            reg_wr = 0, reg_rd = 0;
  logic [AW-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NREQ-1:0] req_in = '0;
  logic [NCH-1:0]  flags = '0;
  logic [NCH-1:0]  ch_req;
  logic            irq_any;

  int n_run = 0, n_fail = 0;
  logic [31:0] rd_val;

  dreq_route_hub #(.NUM_REQ(NREQ), .NUM_CH(NCH), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
    .ch_irq_flags(flags), .ch_req(ch_req), .irq_any(irq_any)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // entry: {line, written byte, expect: bit7 = none, bits 4:0 = channel}
  localparam logic [23:0] VEC [7] = '{
    {8'd0,   8'h83, 8'h03},
    {8'd63,  8'h97, 8'h17},
    {8'd64,  8'h80, 8'h00},
    {8'd127, 8'h8C, 8'h0C},
    {8'd5,   8'h03, 8'h80},
    {8'd70,  8'h9E, 8'h80},
    {8'd10,  8'h98, 8'h80}
  };

  function automatic logic [AW-1:0] line_addr(int line);
    return (line < 64) ? AW'('h100 + 4*line) : AW'('h1100 + 4*(line-64));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic drive_req(logic [NREQ-1:0] v);
    @(negedge clk); req_in = v;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 ch_req", 32'(ch_req), 0);
    check("R1 irq_any", 32'(irq_any), 0);
    rd(line_addr(0), rd_val);   check("R1 map0", rd_val, 0);
    rd(line_addr(127), rd_val); check("R1 map127", rd_val, 0);

    // table walk: R2 R3 readback, R4 routing, R5 invalid, R6 channel range
    for (int i = 0; i < 7; i++) begin
      int line = int'(VEC[i][23:16]);
      logic [NCH-1:0] exp_req;
      wr(line_addr(line), {24'h0, VEC[i][15:8]});
      rd(line_addr(line), rd_val);
      check(line < 64 ? "R2 readback" : "R3 readback", rd_val, {24'h0, VEC[i][15:8]});
      exp_req = VEC[i][7] ? '0 : (NCH'(1) << VEC[i][4:0]);
      drive_req(NREQ'(1) << line);
      check(VEC[i][7] ? (VEC[i][15] ? "R6 route" : "R5 route") : "R4 route",
            32'(ch_req), 32'(exp_req));
      drive_req('0);
      check("R4 release", 32'(ch_req), 0);
    end

    // R10 two lines onto channel 5
    wr(line_addr(1), 32'h85);
    wr(line_addr(100), 32'h85);
    drive_req(NREQ'(1) << 100);
    check("R10 line100", 32'(ch_req), 32'h20);
    drive_req((NREQ'(1) << 100) | (NREQ'(1) << 1));
    check("R10 both", 32'(ch_req), 32'h20);
    drive_req('0);

    // R5 zero write removes line 0 route
    wr(line_addr(0), 32'h0);
    rd(line_addr(0), rd_val); check("R5 cleared readback", rd_val, 0);
    drive_req(NREQ'(1));
    check("R5 cleared route", 32'(ch_req), 0);
    drive_req('0);

    // R9 unmapped address aliasing slot of line 0
    wr(AW'('h200), 32'h87);
    rd(AW'('h200), rd_val);   check("R9 stray read", rd_val, 0);
    rd(line_addr(0), rd_val); check("R9 line0 untouched", rd_val, 0);

    // R7 R8 summary
    @(negedge clk); flags = 24'h800001;
    @(negedge clk);
    check("R8 irq set", 32'(irq_any), 1);
    rd(AW'('hF0), rd_val); check("R7 summary", rd_val, 32'h800001);
    wr(AW'('hF0), 32'hFFFFFFFF);
    rd(AW'('hF0), rd_val); check("R7 read-only", rd_val, 32'h800001);
    @(negedge clk); flags = '0;
    @(negedge clk);
    check("R8 irq clear", 32'(irq_any), 0);
    rd(AW'('hF0), rd_val); check("R7 summary clear", rd_val, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule